// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers 96 level-sensitive interrupt lines, organized as three banks of 32, and raises a single processor interrupt. Software programs it through a simple register port. Each write takes effect at the clock edge, and reads return data combinationally from the address. Each source has a mask bit and a 6-bit priority. A global threshold keeps less urgent sources out of the sort.

When an eligible source appears while nothing is outstanding, the controller captures the most urgent candidate and watches it for a fixed sorting window. At the end of the window it publishes the source number in a sorted-result register. If the captured source dropped, or any mask register was written during the window, the result carries a spurious marker and no interrupt is raised. A valid result holds the processor interrupt high until software writes the acknowledge bit, and the next sort may then start.

A soft reset returns every register to its reset value over a short busy period, and a done flag reports when it has finished. A revision register, an autoidle storage bit and a protection storage bit complete the map.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 (masked), every priority, the threshold, the protection bit and the sorted-result register (0x40) read 0, `irqOut` is low, and the status register 0x14 bit 0 reads 1.
- R2: The bank b mask register at 0x84+0x20*b (1 = masked) can be written directly. Writing 1s to the alias at 0x88+0x20*b clears those mask bits, writing 1s to the alias at 0x8C+0x20*b sets them, and 0 bits in either alias leave the mask unchanged. Other banks are unaffected.
- R3: The pending register at 0x98+0x20*b reads the bank's input lines AND NOT its mask bits.
- R4: The priority register of source i is at 0x100+4*i, with the priority in bits 7:2 and bits 1:0 reading 0. The sort picks the eligible source with the smallest priority value, and on a tie the lowest source number wins.
- R5: A source is eligible only if it is active, unmasked, and its priority is strictly below the threshold at 0x68 (bits 7:0). A threshold of 0xFF admits every active, unmasked source.
- R6: A sort starts at the first clock edge where an eligible source exists while idle. Ten edges later, `irqOut` rises and register 0x40 holds the source number in bits 6:0 with bits 31:7 zero.
- R7: If the captured source is low at any edge of the window, or any mask or mask-alias register is written during it, register 0x40 bits 31:7 read all ones with bits 6:0 holding the source number, and `irqOut` stays low.
- R8: `irqOut` stays high, and register 0x40 stays unchanged, until a write to 0x48 with bit 0 set. A write to 0x48 with bit 0 clear has no effect. `irqOut` falls at the edge of the acknowledge write.
- R9: After an acknowledge, or after a spurious result, a new sort starts at the next edge if an eligible source exists.
- R10: Writing 0x10 with bit 1 set starts a soft reset. Status 0x14 bit 0 reads 0 for four cycles and then 1. All registers return to their R1 values, and `irqOut` is low. Bit 0 of 0x10 is a read/write autoidle bit, and bit 1 reads 0.
- R11: Register 0x00 reads 0x21 (major 2 in bits 7:4, minor 1 in bits 3:0). Register 0x4C bit 0 is a read/write protection bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIrq | input | 96 | Level-sensitive interrupt lines, bit i is source i |
| busAddr | input | 12 | Byte address of the register access |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Processor interrupt request |

## Verification
The sort is exercised with a single source, to measure the exact ten-edge latency. It is also run with three simultaneous sources, two of them sharing a priority, which separates the priority comparison from the index tie-break. Dropping the winner before acknowledging shows that the result register is frozen while an interrupt is outstanding, and it shows the order in which the remaining sources are served. A threshold equal to a source's priority separates strict from inclusive comparison. The two spurious cases, a source dropping mid-window and a mask write to an unrelated bank mid-window, show that both abort conditions are detected and that a still-eligible source is re-sorted immediately afterwards.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int THR_W  = 8;

  localparam logic [ADDR_W-1:0] A_REVISION = 12'h000;
  localparam logic [ADDR_W-1:0] A_SYSCFG   = 12'h010;
  localparam logic [ADDR_W-1:0] A_STATUS   = 12'h014;
  localparam logic [ADDR_W-1:0] A_SORTED   = 12'h040;
  localparam logic [ADDR_W-1:0] A_ACK      = 12'h048;
  localparam logic [ADDR_W-1:0] A_PROTECT  = 12'h04C;
  localparam logic [ADDR_W-1:0] A_THRESH   = 12'h068;
  localparam logic [ADDR_W-1:0] A_MASK0    = 12'h084;
  localparam logic [ADDR_W-1:0] A_UNMASK0  = 12'h088;
  localparam logic [ADDR_W-1:0] A_DOMASK0  = 12'h08C;
  localparam logic [ADDR_W-1:0] A_PEND0    = 12'h098;
  localparam logic [ADDR_W-1:0] A_PRIO0    = 12'h100;
  localparam int BANK_STRIDE = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SORT = 2'd1,
    ST_WAIT = 2'd2
  } sortState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic captureWin;
    logic loadSorted;
    logic sortedSpur;
    logic softRst;
  } ctlStrobes_t;

  function automatic logic [ADDR_W-1:0] bankAddr(input logic [ADDR_W-1:0] base, input int bank);
    return base + ADDR_W'(BANK_STRIDE * bank);
  endfunction
endpackage

// File: rtl/vec_irq_datapath.sv
`timescale 1ns/1ps
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int PRIO_W    = 6,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BANKS*BANK_W-1:0]   srcIrq,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWr,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  input  ctlStrobes_t                   strb,
  input  logic                          rstDone,
  output logic                          anyElig,
  output logic                          winLive,
  output logic                          maskWr,
  output logic                          ackWr,
  output logic                          softRstReq
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] PRIO_END = A_PRIO0 + ADDR_W'(4 * NUM_SRC);

  logic                 wrEff;
  logic [NUM_SRC-1:0]   maskFlat;
  logic [NUM_BANKS-1:0] maskWrB;
  logic [PRIO_W-1:0]    prioR [NUM_SRC];
  logic [THR_W-1:0]     thrR;
  logic                 protR;
  logic                 autoIdleR;
  logic [DATA_W-1:0]    sortedR;
  logic [ID_W-1:0]      winR;
  logic [NUM_SRC-1:0]   elig;
  logic [ID_W-1:0]      bestId;
  logic [PRIO_W-1:0]    bestPrio;
  logic                 prioHit;
  logic [ADDR_W-1:0]    prioOff;
  logic [ID_W-1:0]      prioIdx;

  assign wrEff      = busWr && !strb.softRst;
  assign ackWr      = wrEff && (busAddr == A_ACK) && busWrData[0];
  assign softRstReq = wrEff && (busAddr == A_SYSCFG) && busWrData[1];
  assign maskWr     = |maskWrB;

  assign prioOff = busAddr - A_PRIO0;
  assign prioIdx = ID_W'(prioOff >> 2);
  assign prioHit = (busAddr >= A_PRIO0) && (busAddr < PRIO_END) && (busAddr[1:0] == 2'b00);

  // Per-bank mask register with set and clear aliases
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_M = bankAddr(A_MASK0, b);
    localparam logic [ADDR_W-1:0] A_C = bankAddr(A_UNMASK0, b);
    localparam logic [ADDR_W-1:0] A_S = bankAddr(A_DOMASK0, b);
    logic [BANK_W-1:0] maskQ;
    logic hitM, hitC, hitS;
    assign hitM = wrEff && (busAddr == A_M);
    assign hitC = wrEff && (busAddr == A_C);
    assign hitS = wrEff && (busAddr == A_S);
    assign maskWrB[b] = hitM || hitC || hitS;
    assign maskFlat[b*BANK_W +: BANK_W] = maskQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             maskQ <= '1;
      else if (strb.softRst) maskQ <= '1;
      else if (hitM)         maskQ <= busWrData[BANK_W-1:0];
      else if (hitS)         maskQ <= maskQ | busWrData[BANK_W-1:0];
      else if (hitC)         maskQ <= maskQ & ~busWrData[BANK_W-1:0];
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || strb.softRst) begin
      for (int i = 0; i < NUM_SRC; i++) prioR[i] <= '0;
      thrR      <= '0;
      protR     <= 1'b0;
      autoIdleR <= 1'b0;
    end else if (wrEff) begin
      if (prioHit) prioR[prioIdx] <= busWrData[PRIO_W+1:2];
      if (busAddr == A_THRESH)  thrR      <= busWrData[THR_W-1:0];
      if (busAddr == A_PROTECT) protR     <= busWrData[0];
      if (busAddr == A_SYSCFG)  autoIdleR <= busWrData[0];
    end
  end

  // Captured winner and sorted-result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winR    <= '0;
      sortedR <= '0;
    end else if (strb.softRst) begin
      winR    <= '0;
      sortedR <= '0;
    end else begin
      if (strb.captureWin) winR <= bestId;
      if (strb.loadSorted) sortedR <= {{(DATA_W-ID_W){strb.sortedSpur}}, winR};
    end
  end

  assign winLive = srcIrq[winR];

  // Eligibility and priority selection: strict less-than keeps lowest index on ties
  always_comb begin
    anyElig  = 1'b0;
    bestId   = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = srcIrq[i] && !maskFlat[i] &&
                ((thrR == '1) || (THR_W'(prioR[i]) < thrR));
      if (elig[i] && (!anyElig || prioR[i] < bestPrio)) begin
        anyElig  = 1'b1;
        bestPrio = prioR[i];
        bestId   = ID_W'(i);
      end
    end
  end

  // Read port
  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_REVISION: busRdData[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
      A_SYSCFG:   busRdData[0]   = autoIdleR;
      A_STATUS:   busRdData[0]   = rstDone;
      A_SORTED:   busRdData      = sortedR;
      A_PROTECT:  busRdData[0]   = protR;
      A_THRESH:   busRdData[THR_W-1:0] = thrR;
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busAddr == bankAddr(A_MASK0, b))
        busRdData = DATA_W'(maskFlat[b*BANK_W +: BANK_W]);
      if (busAddr == bankAddr(A_PEND0, b))
        busRdData = DATA_W'(srcIrq[b*BANK_W +: BANK_W] & ~maskFlat[b*BANK_W +: BANK_W]);
    end
    if (prioHit) busRdData = DATA_W'({prioR[prioIdx], 2'b00});
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureWin |-> (srcIrq[bestId] && !maskFlat[bestId])) else $error("winner not active and unmasked"); // R4
  AST_SPUR_MARKS_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSorted && !strb.softRst) |=> (sortedR[DATA_W-1] == $past(strb.sortedSpur))) else $error("spurious marker wrong"); // R7
endmodule

// File: rtl/vec_irq_control.sv
`timescale 1ns/1ps
module vec_irq_control
  import vec_irq_pkg::*;
#(
  parameter int SORT_CYCLES = 10,
  parameter int RST_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyElig,
  input  logic        winLive,
  input  logic        maskWr,
  input  logic        ackWr,
  input  logic        softRstReq,
  output ctlStrobes_t strb,
  output logic        irqOut,
  output logic        rstDone
);
  localparam int CNT_W  = $clog2(SORT_CYCLES + 1);
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);

  sortState_t        state;
  logic [CNT_W-1:0]  sortCnt;
  logic              spurFlag;
  logic              rstBusy;
  logic [RCNT_W-1:0] rstCnt;
  logic              lastCyc;
  logic              spurNow;

  assign lastCyc = (state == ST_SORT) && (sortCnt == CNT_W'(SORT_CYCLES - 1));
  assign spurNow = spurFlag || !winLive || maskWr;

  always_comb begin
    strb.softRst    = rstBusy;
    strb.captureWin = (state == ST_IDLE) && anyElig && !rstBusy;
    strb.loadSorted = lastCyc && !rstBusy;
    strb.sortedSpur = spurNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sortCnt  <= '0;
      spurFlag <= 1'b0;
      rstBusy  <= 1'b0;
      rstCnt   <= '0;
    end else if (softRstReq && !rstBusy) begin
      rstBusy <= 1'b1;
      rstCnt  <= RCNT_W'(RST_CYCLES);
      state   <= ST_IDLE;
    end else if (rstBusy) begin
      rstCnt <= rstCnt - 1'b1;
      if (rstCnt == RCNT_W'(1)) rstBusy <= 1'b0;
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (anyElig) begin
          state    <= ST_SORT;
          sortCnt  <= '0;
          spurFlag <= 1'b0;
        end
        ST_SORT: if (lastCyc) begin
          state <= spurNow ? ST_IDLE : ST_WAIT;
        end else begin
          sortCnt  <= sortCnt + 1'b1;
          spurFlag <= spurNow;
        end
        ST_WAIT: if (ackWr) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign irqOut  = (state == ST_WAIT);
  assign rstDone = !rstBusy;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackWr && !softRstReq) |=> irqOut) else $error("irq dropped without ack"); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ackWr) |=> !irqOut) else $error("irq held after ack"); // R8
  AST_NO_SORT_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !strb.captureWin) else $error("sort while outstanding"); // R8
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |-> !irqOut) else $error("irq during soft reset"); // R10
  AST_SPUR_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSorted && strb.sortedSpur) |=> !irqOut) else $error("irq on spurious sort"); // R7
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int PRIO_W      = 6,
  parameter int SORT_CYCLES = 10,
  parameter int RST_CYCLES  = 4,
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] srcIrq,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWr,
  input  logic [DATA_W-1:0]           busWrData,
  output logic [DATA_W-1:0]           busRdData,
  output logic                        irqOut
);
  ctlStrobes_t strb;
  logic anyElig, winLive, maskWr, ackWr, softRstReq, rstDone;

  vec_irq_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .PRIO_W(PRIO_W),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData),
    .strb(strb), .rstDone(rstDone),
    .anyElig(anyElig), .winLive(winLive), .maskWr(maskWr),
    .ackWr(ackWr), .softRstReq(softRstReq)
  );

  vec_irq_control #(
    .SORT_CYCLES(SORT_CYCLES), .RST_CYCLES(RST_CYCLES)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .anyElig(anyElig), .winLive(winLive), .maskWr(maskWr),
    .ackWr(ackWr), .softRstReq(softRstReq),
    .strb(strb), .irqOut(irqOut), .rstDone(rstDone)
  );
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] srcIrq = '0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [11:0] REV = 12'h000, SYS = 12'h010, STAT = 12'h014, SORTED = 12'h040;
  localparam logic [11:0] ACK = 12'h048, PROT = 12'h04C, THR = 12'h068;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] maskA(int b);   return 12'(12'h084 + 32*b); endfunction
  function automatic logic [11:0] clrA(int b);    return 12'(12'h088 + 32*b); endfunction
  function automatic logic [11:0] setA(int b);    return 12'(12'h08C + 32*b); endfunction
  function automatic logic [11:0] pendA(int b);   return 12'(12'h098 + 32*b); endfunction
  function automatic logic [11:0] prioA(int i);   return 12'(12'h100 + 4*i); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(req, busRdData, exp);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    for (int b = 0; b < 3; b++) rdChk("R1 mask reset", maskA(b), 32'hFFFF_FFFF);
    rdChk("R1 threshold reset", THR, 32'h0);
    rdChk("R1 protection reset", PROT, 32'h0);
    rdChk("R1 priority reset", prioA(70), 32'h0);
    rdChk("R1 sorted reset", SORTED, 32'h0);
    rdChk("R1 status done", STAT, 32'h1);
    chk("R1 irqOut reset", {31'b0, irqOut}, 32'h0);
    rdChk("R11 revision", REV, 32'h21);
  endtask

  task automatic t_protect;
    wr(PROT, 32'h1);
    rdChk("R11 protection set", PROT, 32'h1);
    wr(PROT, 32'h0);
    rdChk("R11 protection clear", PROT, 32'h0);
  endtask

  task automatic t_mask_alias;
    wr(clrA(1), 32'h0000_00F0);
    rdChk("R2 clear alias", maskA(1), 32'hFFFF_FF0F);
    wr(setA(1), 32'h0000_0010);
    rdChk("R2 set alias", maskA(1), 32'hFFFF_FF1F);
    wr(clrA(1), 32'h0);
    rdChk("R2 zero write no effect", maskA(1), 32'hFFFF_FF1F);
    rdChk("R2 other bank untouched", maskA(2), 32'hFFFF_FFFF);
    wr(maskA(1), 32'hFFFF_FFFF);
    rdChk("R2 direct write", maskA(1), 32'hFFFF_FFFF);
  endtask

  task automatic t_pending;
    srcIrq[31:0] = 32'h0000_00A5;
    wr(clrA(0), 32'h0000_000F);
    rdChk("R3 pending masked view", pendA(0), 32'h0000_0005);
    rdChk("R3 pending other bank", pendA(1), 32'h0);
    srcIrq = '0;
    wr(setA(0), 32'h0000_000F);
    rdChk("R3 pending after remask", pendA(0), 32'h0);
  endtask

  task automatic t_sort_timing;
    srcIrq[5] = 1'b1;
    waitN(10);
    chk("R6 irq low before window end", {31'b0, irqOut}, 32'h0);
    waitN(1);
    chk("R6 irq high at window end", {31'b0, irqOut}, 32'h1);
    rdChk("R6 sorted id", SORTED, 32'd5);
    wr(ACK, 32'h0);
    chk("R8 ack bit clear ignored", {31'b0, irqOut}, 32'h1);
    srcIrq[5] = 1'b0;
    wr(ACK, 32'h1);
    chk("R8 ack drops irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_priority;
    wr(prioA(10), 32'd7 << 2);
    wr(prioA(33), 32'd3 << 2);
    wr(prioA(70), 32'd3 << 2);
    rdChk("R4 priority readback", prioA(33), 32'h0C);
    srcIrq[10] = 1'b1; srcIrq[33] = 1'b1; srcIrq[70] = 1'b1;
    waitN(11);
    chk("R4 irq after sort", {31'b0, irqOut}, 32'h1);
    rdChk("R4 tie to lowest index", SORTED, 32'd33);
    srcIrq[33] = 1'b0;
    waitN(3);
    chk("R8 irq held while outstanding", {31'b0, irqOut}, 32'h1);
    rdChk("R8 sorted frozen", SORTED, 32'd33);
    wr(ACK, 32'h1);
    waitN(11);
    chk("R9 resort after ack", {31'b0, irqOut}, 32'h1);
    rdChk("R9 next winner", SORTED, 32'd70);
    srcIrq[70] = 1'b0;
    wr(ACK, 32'h1);
    waitN(11);
    rdChk("R4 least urgent last", SORTED, 32'd10);
    srcIrq[10] = 1'b0;
    wr(ACK, 32'h1);
    waitN(12);
    chk("R9 idle with nothing eligible", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_threshold;
    wr(THR, 32'd7);
    srcIrq[10] = 1'b1;
    waitN(12);
    chk("R5 priority equal threshold blocked", {31'b0, irqOut}, 32'h0);
    srcIrq[70] = 1'b1;
    waitN(11);
    chk("R5 priority below threshold", {31'b0, irqOut}, 32'h1);
    rdChk("R5 sorted under threshold", SORTED, 32'd70);
    srcIrq[70] = 1'b0;
    wr(ACK, 32'h1);
    waitN(12);
    chk("R5 blocked source stays quiet", {31'b0, irqOut}, 32'h0);
    wr(THR, 32'hFF);
    waitN(11);
    chk("R5 threshold FF admits all", {31'b0, irqOut}, 32'h1);
    rdChk("R5 sorted with threshold off", SORTED, 32'd10);
    srcIrq[10] = 1'b0;
    wr(ACK, 32'h1);
  endtask

  task automatic t_spur_drop;
    srcIrq[5] = 1'b1;
    waitN(3);
    srcIrq[5] = 1'b0;
    waitN(8);
    chk("R7 no irq on dropped winner", {31'b0, irqOut}, 32'h0);
    rdChk("R7 spurious marker drop", SORTED, 32'hFFFF_FF85);
    waitN(5);
    chk("R7 stays quiet", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_spur_mask;
    srcIrq[40] = 1'b1;
    waitN(3);
    wr(setA(2), 32'h0);
    waitN(7);
    chk("R7 no irq on mask write", {31'b0, irqOut}, 32'h0);
    rdChk("R7 spurious marker mask", SORTED, 32'hFFFF_FFA8);
    waitN(10);
    chk("R9 resort window running", {31'b0, irqOut}, 32'h0);
    waitN(1);
    chk("R9 resort after spurious", {31'b0, irqOut}, 32'h1);
    rdChk("R9 valid after spurious", SORTED, 32'd40);
    srcIrq[40] = 1'b0;
    wr(ACK, 32'h1);
  endtask

  task automatic t_soft_reset;
    srcIrq[5] = 1'b1;
    waitN(11);
    chk("R10 irq before soft reset", {31'b0, irqOut}, 32'h1);
    wr(SYS, 32'h3);
    chk("R10 irq low in soft reset", {31'b0, irqOut}, 32'h0);
    rdChk("R10 status busy", STAT, 32'h0);
    waitN(3);
    rdChk("R10 status busy last", STAT, 32'h0);
    waitN(1);
    rdChk("R10 status done", STAT, 32'h1);
    rdChk("R10 mask restored", maskA(0), 32'hFFFF_FFFF);
    rdChk("R10 threshold restored", THR, 32'h0);
    rdChk("R10 priority restored", prioA(33), 32'h0);
    rdChk("R10 sorted restored", SORTED, 32'h0);
    rdChk("R10 sysconfig restored", SYS, 32'h0);
    waitN(12);
    chk("R10 masked source quiet", {31'b0, irqOut}, 32'h0);
    wr(SYS, 32'h1);
    rdChk("R10 autoidle readback", SYS, 32'h1);
    srcIrq = '0;
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    t_reset_state();
    t_protect();
    t_mask_alias();
    t_pending();
    wr(THR, 32'hFF);
    for (int b = 0; b < 3; b++) wr(clrA(b), 32'hFFFF_FFFF);
    t_sort_timing();
    t_priority();
    t_threshold();
    t_spur_drop();
    t_spur_mask();
    t_soft_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule